// File: doc/BRIEF.md
# Move-Only Transport Datapath

This block is a processor datapath with a single kind of instruction: a move that copies a value from a numbered source to a numbered destination. Each instruction word carries two move slots that run in parallel over a shared interconnect. The endpoints on this interconnect are:

- eight general registers;
- an arithmetic unit with an operand input, a trigger input and a result output;
- a second function unit of the same shape that multiplies.

No instruction selects an operation. A unit computes only because a value lands on its trigger input. For the arithmetic unit, the trigger address chooses the operation. A register-to-register add therefore takes three moves: one register to the operand input, the other register to the add trigger, and the result output back to a register.

The datapath has no stall and no hazard detection. The order in which values become visible is fixed by the rules below, and the instruction sequence must be arranged around them. The stream comes from outside with a valid flag. Fetch and branching are not part of the block.

Each word is 34 bits wide. Bits 33..18 hold a 16-bit immediate. Bits 17..9 hold slot 1 and bits 8..0 hold slot 0. Each slot is {valid, src[3:0], dst[3:0]}, with the valid bit as the MSB.

Source ids:
- 0-7: registers r0..r7
- 8: arithmetic result
- 9: multiplier result
- 15: the word's immediate
- 10-14: read as zero

Destination ids:
- 0-7: registers
- 8: arithmetic operand
- 9: trigger for add
- 10: trigger for sub
- 11: trigger for and
- 12: trigger for or
- 13: trigger for xor
- 14: multiplier operand
- 15: multiplier trigger

Top module: `tta_move_core`

## Requirements
- R1: After reset, all eight registers, both result outputs and `conflict_o` read zero.
- R2: A move with source 15 writes the immediate field to its destination. All sources are read before any write of the same word, so two slots that cross-copy r1 and r2 swap them.
- R3: A trigger move to destination 9, 10, 11, 12 or 13 computes operand+value, operand−value, AND, OR or XOR respectively (16-bit, wrapping). The result appears on `alu_res_o` one cycle after the word and can be read as source 8 by the next word.
- R4: The operand moved to destination 8 is kept across words. If the same word also writes a trigger, the computation uses the operand moved in that word.
- R5: A result output keeps its value until its unit is triggered again.
- R6: Destination 14 latches the multiplier operand. Destination 15 triggers it, and the low 16 bits of operand×value appear on `sfu_res_o` the next cycle. Source 9 reads that result.
- R7: Both slots execute in the same cycle, including two register writes to different registers.
- R8: Two valid slots conflict when they name the same destination. All of destinations 9–13 count as one destination for this rule. In a conflict, slot 0's move takes effect, slot 1's move is dropped, and `conflict_o` is high for exactly the cycle after that word.
- R9: With `instr_valid_i` low, or with a slot's valid bit low, that word or slot changes no register, operand or result.
- R10: Sources 10 to 14 read as zero.
- R11: A word that reads source 8 while it also triggers the arithmetic unit receives the result from before that trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 34 | {imm[15:0], slot1[8:0], slot0[8:0]} |
| regs_o | output | 128 | Register contents, r0 in bits 15..0 |
| alu_res_o | output | 16 | Arithmetic unit result output |
| sfu_res_o | output | 16 | Multiplier result output |
| conflict_o | output | 1 | Destination clash in the previous word |

## Verification
The hardest situation to reach from the ports is a word whose two slots interact:
- both slots target the arithmetic trigger group under different operation addresses;
- an operand move and a trigger share a word;
- a result is read while it is being recomputed.

Uniform random stimulus seldom lines up with these. So the random generator draws destinations from a narrow pool (8–15 and two registers) about half the time, which makes such collisions frequent. Directed words also build each case explicitly: the three-move add, the swap, a same-word operand and trigger, a read of source 8 alongside a trigger, and grouped-trigger conflicts.

// File: rtl/tta_pkg.sv
package tta_pkg;
    localparam int DATA_W  = 16;
    localparam int NREG    = 8;
    localparam int ID_W    = 4;
    localparam int NSLOT   = 2;
    localparam int RADDR_W = $clog2(NREG);
    localparam int SLOT_W  = 1 + 2 * ID_W;
    localparam int INSTR_W = DATA_W + NSLOT * SLOT_W;

    localparam logic [ID_W-1:0] SRC_ALU_RES = 4'd8;
    localparam logic [ID_W-1:0] SRC_SFU_RES = 4'd9;
    localparam logic [ID_W-1:0] SRC_IMM     = 4'd15;

    localparam logic [ID_W-1:0] DST_ALU_OPD = 4'd8;
    localparam logic [ID_W-1:0] DST_ADD     = 4'd9;
    localparam logic [ID_W-1:0] DST_SUB     = 4'd10;
    localparam logic [ID_W-1:0] DST_AND     = 4'd11;
    localparam logic [ID_W-1:0] DST_OR      = 4'd12;
    localparam logic [ID_W-1:0] DST_XOR     = 4'd13;
    localparam logic [ID_W-1:0] DST_SFU_OPD = 4'd14;
    localparam logic [ID_W-1:0] DST_SFU_TRG = 4'd15;

    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [2:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_MUL
    } fu_op_e;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] src;
        logic [ID_W-1:0] dst;
    } slot_t;

    typedef struct packed {
        data_t                 imm;
        slot_t [NSLOT-1:0]     slot;
    } instr_t;

    typedef struct packed {
        logic   opd_we;
        data_t  opd;
        logic   trig_we;
        data_t  trig;
        fu_op_e op;
    } fu_in_t;

    // all arithmetic trigger addresses share one physical port
    function automatic logic [ID_W-1:0] dst_group(input logic [ID_W-1:0] d);
        return (d >= DST_ADD && d <= DST_XOR) ? DST_ADD : d;
    endfunction

    function automatic data_t fu_eval(input fu_op_e op, input data_t a, input data_t b);
        data_t r;
        case (op)
            OP_ADD:  r = a + b;
            OP_SUB:  r = a - b;
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_MUL:  r = a * b;
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/tta_regfile.sv
module tta_regfile
    import tta_pkg::*;
#(
    parameter int N_REG = NREG,
    parameter int N_PORT = NSLOT,
    localparam int AW = $clog2(N_REG)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_PORT-1:0]       we,
    input  logic [N_PORT-1:0][AW-1:0] waddr,
    input  data_t [N_PORT-1:0]      wdata,
    input  logic [N_PORT-1:0][AW-1:0] raddr,
    output data_t [N_PORT-1:0]      rdata,
    output data_t [N_REG-1:0]       regs
);
    data_t [N_REG-1:0] rf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_q <= '0;
        end else begin
            for (int p = 0; p < N_PORT; p++) begin
                if (we[p]) rf_q[waddr[p]] <= wdata[p];
            end
        end
    end

    for (genvar p = 0; p < N_PORT; p++) begin : g_rd
        assign rdata[p] = rf_q[raddr[p]];
    end

    assign regs = rf_q;

    // R7: the interconnect never hands two ports the same register
    assert_dual_write_R7: assert property (@(posedge clk) disable iff (rst)
        (we[0] && we[1]) |-> (waddr[0] != waddr[1]));
endmodule

// File: rtl/tta_fu.sv
module tta_fu
    import tta_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  fu_in_t req,
    output data_t  res
);
    data_t opd_q;
    data_t res_q;
    data_t opd_eff;

    // operand moved in the same word as the trigger takes effect at once
    assign opd_eff = req.opd_we ? req.opd : opd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            opd_q <= '0;
            res_q <= '0;
        end else begin
            if (req.opd_we)  opd_q <= req.opd;
            if (req.trig_we) res_q <= fu_eval(req.op, opd_eff, req.trig);
        end
    end

    assign res = res_q;

    // R5: the result port moves only after a trigger
    assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req.trig_we)) |-> $stable(res_q));
endmodule

// File: rtl/tta_xbar.sv
module tta_xbar
    import tta_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         valid,
    input  slot_t [NSLOT-1:0]            slots,
    input  data_t [NSLOT-1:0]            src_data,
    output logic [NSLOT-1:0]             rf_we,
    output logic [NSLOT-1:0][RADDR_W-1:0] rf_waddr,
    output data_t [NSLOT-1:0]            rf_wdata,
    output fu_in_t                       alu_req,
    output fu_in_t                       sfu_req,
    output logic                         clash
);
    logic [NSLOT-1:0] keep;

    always_comb begin
        clash = 1'b0;
        for (int k = 0; k < NSLOT; k++) begin
            keep[k] = valid && slots[k].valid;
            for (int j = 0; j < k; j++) begin
                if (valid && slots[j].valid && slots[k].valid &&
                    dst_group(slots[j].dst) == dst_group(slots[k].dst)) begin
                    keep[k] = 1'b0;
                    clash   = 1'b1;
                end
            end
        end
    end

    always_comb begin
        rf_we    = '0;
        rf_waddr = '0;
        rf_wdata = '0;
        alu_req  = '{opd_we: 1'b0, opd: '0, trig_we: 1'b0, trig: '0, op: OP_ADD};
        sfu_req  = '{opd_we: 1'b0, opd: '0, trig_we: 1'b0, trig: '0, op: OP_MUL};
        for (int k = 0; k < NSLOT; k++) begin
            if (keep[k]) begin
                if (slots[k].dst < ID_W'(NREG)) begin
                    rf_we[k]    = 1'b1;
                    rf_waddr[k] = slots[k].dst[RADDR_W-1:0];
                    rf_wdata[k] = src_data[k];
                end else begin
                    case (slots[k].dst)
                        DST_ALU_OPD: begin
                            alu_req.opd_we = 1'b1;
                            alu_req.opd    = src_data[k];
                        end
                        DST_ADD, DST_SUB, DST_AND, DST_OR, DST_XOR: begin
                            alu_req.trig_we = 1'b1;
                            alu_req.trig    = src_data[k];
                            case (slots[k].dst)
                                DST_SUB: alu_req.op = OP_SUB;
                                DST_AND: alu_req.op = OP_AND;
                                DST_OR:  alu_req.op = OP_OR;
                                DST_XOR: alu_req.op = OP_XOR;
                                default: alu_req.op = OP_ADD;
                            endcase
                        end
                        DST_SFU_OPD: begin
                            sfu_req.opd_we = 1'b1;
                            sfu_req.opd    = src_data[k];
                        end
                        default: begin
                            sfu_req.trig_we = 1'b1;
                            sfu_req.trig    = src_data[k];
                        end
                    endcase
                end
            end
        end
    end

    // R8: a clash always leaves slot 0 in force
    assert_clash_keeps_slot0_R8: assert property (@(posedge clk) disable iff (rst)
        clash |-> (keep[0] && !keep[1]));
endmodule

// File: rtl/tta_move_core.sv
module tta_move_core
    import tta_pkg::*;
#(
    parameter bit HAS_SFU = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    instr_valid_i,
    input  logic [INSTR_W-1:0]      instr_i,
    output logic [NREG*DATA_W-1:0]  regs_o,
    output logic [DATA_W-1:0]       alu_res_o,
    output logic [DATA_W-1:0]       sfu_res_o,
    output logic                    conflict_o
);
    instr_t                        instr;
    data_t [NSLOT-1:0]             src_data;
    data_t [NSLOT-1:0]             rf_rdata;
    logic  [NSLOT-1:0][RADDR_W-1:0] rf_raddr;
    logic  [NSLOT-1:0]             rf_we;
    logic  [NSLOT-1:0][RADDR_W-1:0] rf_waddr;
    data_t [NSLOT-1:0]             rf_wdata;
    data_t [NREG-1:0]              regs;
    fu_in_t                        alu_req;
    fu_in_t                        sfu_req;
    data_t                         alu_res;
    data_t                         sfu_res;
    logic                          clash;
    logic                          conflict_q;

    assign instr = instr_t'(instr_i);

    // source side of the interconnect
    for (genvar k = 0; k < NSLOT; k++) begin : g_src
        assign rf_raddr[k] = instr.slot[k].src[RADDR_W-1:0];
        always_comb begin
            if (instr.slot[k].src < ID_W'(NREG))       src_data[k] = rf_rdata[k];
            else if (instr.slot[k].src == SRC_ALU_RES) src_data[k] = alu_res;
            else if (instr.slot[k].src == SRC_SFU_RES) src_data[k] = sfu_res;
            else if (instr.slot[k].src == SRC_IMM)     src_data[k] = instr.imm;
            else                                       src_data[k] = '0;
        end
    end

    tta_regfile u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rf_raddr),
        .rdata (rf_rdata),
        .regs  (regs)
    );

    tta_xbar u_xbar (
        .clk      (clk),
        .rst      (rst),
        .valid    (instr_valid_i),
        .slots    (instr.slot),
        .src_data (src_data),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata),
        .alu_req  (alu_req),
        .sfu_req  (sfu_req),
        .clash    (clash)
    );

    tta_fu u_alu (
        .clk (clk),
        .rst (rst),
        .req (alu_req),
        .res (alu_res)
    );

    if (HAS_SFU) begin : g_sfu
        tta_fu u_sfu (
            .clk (clk),
            .rst (rst),
            .req (sfu_req),
            .res (sfu_res)
        );
    end else begin : g_no_sfu
        assign sfu_res = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) conflict_q <= 1'b0;
        else     conflict_q <= clash;
    end

    for (genvar r = 0; r < NREG; r++) begin : g_out
        assign regs_o[r*DATA_W +: DATA_W] = regs[r];
    end
    assign alu_res_o  = alu_res;
    assign sfu_res_o  = sfu_res;
    assign conflict_o = conflict_q;

    // R8: the flag only follows a presented word
    assert_conflict_needs_word_R8: assert property (@(posedge clk) disable iff (rst)
        (conflict_o && !$past(rst)) |-> $past(instr_valid_i));

    // R9: an idle cycle leaves every register and result alone
    assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(instr_valid_i)) |->
            ($stable(regs_o) && $stable(alu_res_o) && $stable(sfu_res_o)));
endmodule

// File: tb/tta_move_core_bench.sv
module tta_move_core_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         instr_valid_i;
    logic [33:0]  instr_i;
    logic [127:0] regs_o;
    logic [15:0]  alu_res_o;
    logic [15:0]  sfu_res_o;
    logic         conflict_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_rf [8];
    logic [15:0] m_opd, m_res, m_sopd, m_sres;
    logic        m_err;

    always #10 clk = ~clk;

    tta_move_core u_tta_move_core (
        .clk (clk), .rst (rst), .instr_valid_i (instr_valid_i), .instr_i (instr_i),
        .regs_o (regs_o), .alu_res_o (alu_res_o), .sfu_res_o (sfu_res_o),
        .conflict_o (conflict_o)
    );

    function automatic logic [33:0] mk(input logic [15:0] imm,
                                       input logic v1, input logic [3:0] s1, input logic [3:0] d1,
                                       input logic v0, input logic [3:0] s0, input logic [3:0] d0);
        return {imm, v1, s1, d1, v0, s0, d0};
    endfunction

    function automatic logic [3:0] grp(input logic [3:0] d);
        return (d >= 9 && d <= 13) ? 4'd9 : d;
    endfunction

    function automatic logic [127:0] m_flat();
        logic [127:0] f;
        for (int i = 0; i < 8; i++) f[i*16 +: 16] = m_rf[i];
        return f;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 8; i++) m_rf[i] = '0;
        m_opd = '0; m_res = '0; m_sopd = '0; m_sres = '0; m_err = 1'b0;
    endtask

    task automatic m_step(input logic v, input logic [33:0] w);
        logic [15:0] sv [2];
        logic        kp [2];
        logic [15:0] n_rf [8];
        logic [15:0] n_opd, n_res, n_sopd, n_sres;
        logic [15:0] imm;
        logic [3:0]  s [2];
        logic [3:0]  d [2];
        logic        sl [2];
        imm = w[33:18];
        sl[1] = w[17]; s[1] = w[16:13]; d[1] = w[12:9];
        sl[0] = w[8];  s[0] = w[7:4];   d[0] = w[3:0];
        for (int k = 0; k < 2; k++) begin
            if (s[k] < 8)        sv[k] = m_rf[s[k][2:0]];
            else if (s[k] == 8)  sv[k] = m_res;
            else if (s[k] == 9)  sv[k] = m_sres;
            else if (s[k] == 15) sv[k] = imm;
            else                 sv[k] = '0;
        end
        kp[0] = v && sl[0];
        kp[1] = v && sl[1] && !(kp[0] && grp(d[0]) == grp(d[1]));
        m_err = v && sl[0] && sl[1] && grp(d[0]) == grp(d[1]);
        for (int i = 0; i < 8; i++) n_rf[i] = m_rf[i];
        n_opd = m_opd; n_res = m_res; n_sopd = m_sopd; n_sres = m_sres;
        for (int k = 0; k < 2; k++) begin
            if (kp[k] && d[k] == 8)  n_opd  = sv[k];
            if (kp[k] && d[k] == 14) n_sopd = sv[k];
        end
        for (int k = 0; k < 2; k++) begin
            if (kp[k]) begin
                case (d[k])
                    4'd8, 4'd14: ;
                    4'd9:  n_res = n_opd + sv[k];
                    4'd10: n_res = n_opd - sv[k];
                    4'd11: n_res = n_opd & sv[k];
                    4'd12: n_res = n_opd | sv[k];
                    4'd13: n_res = n_opd ^ sv[k];
                    4'd15: n_sres = 16'(n_sopd * sv[k]);
                    default: n_rf[d[k][2:0]] = sv[k];
                endcase
            end
        end
        for (int i = 0; i < 8; i++) m_rf[i] = n_rf[i];
        m_opd = n_opd; m_res = n_res; m_sopd = n_sopd; m_sres = n_sres;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (regs_o !== m_flat()) begin
            errors++;
            $display("FAIL %s regs actual=%h expected=%h", tag, regs_o, m_flat());
        end
        checks++;
        if (alu_res_o !== m_res) begin
            errors++;
            $display("FAIL %s alu_res actual=%h expected=%h", tag, alu_res_o, m_res);
        end
        checks++;
        if (sfu_res_o !== m_sres) begin
            errors++;
            $display("FAIL %s sfu_res actual=%h expected=%h", tag, sfu_res_o, m_sres);
        end
        checks++;
        if (conflict_o !== m_err) begin
            errors++;
            $display("FAIL %s conflict actual=%b expected=%b", tag, conflict_o, m_err);
        end
    endtask

    // entered at a falling edge; leaves at the next falling edge
    task automatic apply(input logic v, input logic [33:0] w, input string tag);
        instr_valid_i = v;
        instr_i       = w;
        m_step(v, w);
        @(posedge clk);
        #3;
        compare(tag);
        @(negedge clk);
    endtask

    task automatic expect_val(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        rst = 1'b1; instr_valid_i = 1'b0; instr_i = '0;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        compare("R1_reset");

        // R2: immediate loads
        apply(1, mk(16'd5,    0, 0, 0, 1, 15, 1), "R2_imm_r1");
        apply(1, mk(16'd3,    0, 0, 0, 1, 15, 2), "R2_imm_r2");
        // R3/R4: add in three moves, operand and trigger in one word
        apply(1, mk(16'd0,    1, 2, 9, 1, 1, 8), "R4_opd_same_word");
        expect_val(alu_res_o, 16'd8, "R3_add_result");
        apply(1, mk(16'd0,    0, 0, 0, 1, 8, 3), "R3_read_result");
        expect_val(regs_o[3*16 +: 16], 16'd8, "R3_r3_holds_sum");
        // R4: stored operand reused; R3 sub wraps
        apply(1, mk(16'd9,    0, 0, 0, 1, 15, 10), "R4_latched_opd_sub");
        expect_val(alu_res_o, 16'hFFFC, "R3_sub_wrap");
        apply(1, mk(16'hF0F0, 0, 0, 0, 1, 15, 11), "R3_and");
        apply(1, mk(16'h0F0F, 0, 0, 0, 1, 15, 12), "R3_or");
        apply(1, mk(16'h00FF, 0, 0, 0, 1, 15, 13), "R3_xor");
        // R5: unrelated moves leave the result
        apply(1, mk(16'd77,   1, 15, 6, 1, 15, 7), "R5_hold_R7_dual");
        // R2: swap r1 and r2
        apply(1, mk(16'd0,    1, 2, 1, 1, 1, 2), "R2_swap");
        expect_val(regs_o[1*16 +: 16], 16'd3, "R2_swapped_r1");
        // R11: read result while retriggering
        apply(1, mk(16'd1,    1, 8, 4, 1, 15, 9), "R11_old_result");
        // R6: multiplier
        apply(1, mk(16'd300,  0, 0, 0, 1, 15, 14), "R6_opd");
        apply(1, mk(16'd500,  0, 0, 0, 1, 15, 15), "R6_mul");
        expect_val(sfu_res_o, 16'(300 * 500), "R6_mul_low");
        apply(1, mk(16'd0,    0, 0, 0, 1, 9, 5), "R6_read_src9");
        // R10: empty sources
        apply(1, mk(16'd0,    1, 12, 6, 1, 10, 7), "R10_zero_src");
        // R8: same register, then trigger group clash
        apply(1, mk(16'd0,    1, 1, 4, 1, 2, 4), "R8_same_reg");
        apply(1, mk(16'd0,    0, 0, 0, 0, 0, 0), "R8_flag_drops");
        apply(1, mk(16'd2,    1, 15, 10, 1, 15, 9), "R8_trigger_group");
        // R9: invalid word and invalid slots
        apply(0, mk(16'd9,    1, 15, 1, 1, 15, 9), "R9_word_invalid");
        apply(1, mk(16'd9,    0, 15, 1, 0, 15, 9), "R9_slots_invalid");

        // random words, destinations often drawn from a narrow pool
        for (int n = 0; n < 600; n++) begin
            logic [3:0] d0, d1, s0, s1;
            s0 = 4'($urandom_range(0, 15));
            s1 = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1) begin
                d0 = 4'($urandom_range(8, 15));
                d1 = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 1)) : 4'($urandom_range(8, 15));
            end else begin
                d0 = 4'($urandom_range(0, 15));
                d1 = 4'($urandom_range(0, 15));
            end
            apply(($urandom_range(0, 7) != 0),
                  mk(16'($urandom), 1'($urandom_range(0, 1)), s1, d1,
                     1'($urandom_range(0, 3) != 0), s0, d0),
                  "R7_random");
        end

        instr_valid_i = 1'b0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule